// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Fast Vectors

This controller sits between a set of peripheral interrupt lines and a small DSP-style core. Each line is edge-captured into a pending bit and carries a two-bit priority field that either disables it or places it at level 0, 1 or 2. A separate non-maskable input always runs at level 3. Each cycle the controller finds the best pending request that the core's current priority code allows. It then raises a request strobe together with a vector number, a handler address and a fast flag, and holds all of them until the core acknowledges.

Handler addresses come from one of two paths. A normal request points into a vector table at a programmable base, with two words per entry. Two fast-match registers can each name one vector. When the winner matches one of them and also sits at level 2, the controller gives the core the full handler address held in that match's own pair of half-word registers, and it raises the fast flag. All settings go through a plain register write port with a combinational read port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, `int_req_o` is 0, no request is pending, and every register reads back 0.
- R2: Register offsets are: 0 base low half, 1 base high half, 2 fast match A, 3 fast match B, 4 address A low, 5 address A high, 6 address B low, 7 address B high, and 8 upward the priority words. Source i uses the word at 8 + i/8, bits [2*(i%8)+1 : 2*(i%8)]. Every register reads back what was written, and an offset beyond the last priority word reads 0.
- R3: A rising edge on an enabled source sets its pending bit. A line held high after acknowledge does not request again. An edge on a source whose field is 00 is dropped and is not served if the source is enabled later.
- R4: Field 01, 10 and 11 give levels 0, 1 and 2. With core code c (00, 01, 10, 11), only requests at level c or higher are eligible. Blocked requests stay pending and are served once the code allows them.
- R5: Among eligible requests the highest level wins, and among equal levels the lowest vector number wins.
- R6: The non-maskable input is vector NUM_SRC (16 by default) at level 3. It is eligible under every core code and beats all sources.
- R7: A normal request presents the address {base high, base low} + 2 × vector, with `int_fast_o` = 0.
- R8: When the winner's vector equals a fast match register and its level is 2, the address is {high, low} of that match's address pair and `int_fast_o` = 1.
- R9: When a vector equals a match register but its level is not 2, it is served as a normal request.
- R10: When both match registers hold the winning vector, match A and address pair A are used.
- R11: While `int_req_o` is high, the vector, address and fast flag do not change until `int_ack_i`. The acknowledge drops the strobe for at least one cycle and clears that vector's pending bit. An acknowledge while no request is presented is ignored.
- R12: If the acknowledged source shows a new rising edge in the acknowledge cycle, it stays pending and is requested again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | NUM_SRC | Peripheral interrupt lines, edge-captured |
| nmi_i | input | 1 | Non-maskable line, level 3, edge-captured |
| core_lvl_i | input | 2 | Core's current priority code |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | RAW | Register offset |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Combinational read data |
| int_req_o | output | 1 | Request strobe to the core |
| int_vec_o | output | VEC_W | Presented vector number |
| int_addr_o | output | 2*DW | Presented handler address |
| int_fast_o | output | 1 | Presented request uses the fast path |
| int_ack_i | input | 1 | One-cycle acknowledge from the core |

## Verification
Two events can land in the same clock cycle: the core's acknowledge, which clears a pending bit, and a fresh rising edge on that same source, which sets it. The bench drives the acknowledge and a new edge on the served line in the same cycle. It then expects the strobe to drop for one cycle and come back with the same vector, so a set must win over the clear. A control case acknowledges with no new edge and expects the controller to stay idle.

// File: rtl/pic_pkg.sv
package pic_pkg;

    // register offsets inside the controller's register space
    localparam int OFS_BASE_LO = 0;
    localparam int OFS_BASE_HI = 1;
    localparam int OFS_FM_A    = 2;
    localparam int OFS_FM_B    = 3;
    localparam int OFS_FA_A_LO = 4;
    localparam int OFS_FA_A_HI = 5;
    localparam int OFS_FA_B_LO = 6;
    localparam int OFS_FA_B_HI = 7;
    localparam int OFS_PRIO    = 8;

    localparam logic [1:0] NMI_LEVEL  = 2'd3;
    localparam logic [1:0] FAST_LEVEL = 2'd2;

    typedef enum logic [1:0] {
        PF_OFF = 2'b00,
        PF_L0  = 2'b01,
        PF_L1  = 2'b10,
        PF_L2  = 2'b11
    } prio_field_e;

    function automatic logic [1:0] field_level(input logic [1:0] f);
        return (f == PF_OFF) ? 2'd0 : f - 2'd1;
    endfunction

    function automatic logic field_enabled(input logic [1:0] f);
        return f != PF_OFF;
    endfunction

endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int DW      = 16,
    parameter int NPR     = 2,
    parameter int RAW     = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_i,
    input  logic [RAW-1:0]          addr_i,
    input  logic [DW-1:0]           wdata_i,
    output logic [DW-1:0]           rdata_o,
    output logic [2*DW-1:0]         base_o,
    output logic [DW-1:0]           fm_a_o,
    output logic [DW-1:0]           fm_b_o,
    output logic [2*DW-1:0]         fa_a_o,
    output logic [2*DW-1:0]         fa_b_o,
    output logic [NUM_SRC-1:0][1:0] prio_o
);
    localparam int REG_N = OFS_PRIO + NPR;
    localparam int PER   = DW / 2;

    logic [DW-1:0] regs_q [REG_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < REG_N; k++) regs_q[k] <= '0;
        end else if (wr_i) begin
            for (int k = 0; k < REG_N; k++)
                if (addr_i == RAW'(k)) regs_q[k] <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < REG_N; k++)
            if (addr_i == RAW'(k)) rdata_o = regs_q[k];
    end

    assign base_o = {regs_q[OFS_BASE_HI], regs_q[OFS_BASE_LO]};
    assign fm_a_o = regs_q[OFS_FM_A];
    assign fm_b_o = regs_q[OFS_FM_B];
    assign fa_a_o = {regs_q[OFS_FA_A_HI], regs_q[OFS_FA_A_LO]};
    assign fa_b_o = {regs_q[OFS_FA_B_HI], regs_q[OFS_FA_B_LO]};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_field
        assign prio_o[i] = regs_q[OFS_PRIO + i / PER][2*(i % PER) +: 2];
    end

endmodule

// File: rtl/pic_pending.sv
module pic_pending #(
    parameter int N     = 17,
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     line_i,
    input  logic [N-1:0]     en_i,
    input  logic             clr_i,
    input  logic [VEC_W-1:0] clr_idx_i,
    output logic [N-1:0]     pend_o
);
    logic [N-1:0] line_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] rise_w;

    assign rise_w = line_i & ~line_q & en_i;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                line_q[i] <= 1'b0;
                pend_q[i] <= 1'b0;
            end else begin
                line_q[i] <= line_i[i];
                if (rise_w[i])
                    pend_q[i] <= 1'b1;
                else if (clr_i && clr_idx_i == VEC_W'(i))
                    pend_q[i] <= 1'b0;
            end
        end
    end

    assign pend_o = pend_q;

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clr_i && !rise_w[clr_idx_i] |=> !pend_q[$past(clr_idx_i)]); // R11

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
        (|rise_w) |=> ((pend_q & $past(rise_w)) == $past(rise_w))); // R12

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int N     = 17,
    parameter int VEC_W = 5
) (
    input  logic [N-1:0]       req_i,
    input  logic [N-1:0][1:0]  lvl_i,
    input  logic [1:0]         core_lvl_i,
    output logic               win_valid_o,
    output logic [VEC_W-1:0]   win_vec_o,
    output logic [1:0]         win_lvl_o
);
    // scan downward so an equal level found later (lower vector) replaces
    always_comb begin
        win_valid_o = 1'b0;
        win_vec_o   = '0;
        win_lvl_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i] && lvl_i[i] >= core_lvl_i &&
                (!win_valid_o || lvl_i[i] >= win_lvl_o)) begin
                win_valid_o = 1'b1;
                win_vec_o   = VEC_W'(i);
                win_lvl_o   = lvl_i[i];
            end
        end
    end

endmodule

// File: rtl/pic_vecgen.sv
module pic_vecgen
    import pic_pkg::*;
#(
    parameter int DW    = 16,
    parameter int VEC_W = 5
) (
    input  logic [VEC_W-1:0]  vec_i,
    input  logic [1:0]        lvl_i,
    input  logic [2*DW-1:0]   base_i,
    input  logic [DW-1:0]     fm_a_i,
    input  logic [DW-1:0]     fm_b_i,
    input  logic [2*DW-1:0]   fa_a_i,
    input  logic [2*DW-1:0]   fa_b_i,
    output logic [2*DW-1:0]   addr_o,
    output logic              fast_o
);
    localparam int VA_W = 2 * DW;

    logic hit_a, hit_b;

    assign hit_a = (fm_a_i == DW'(vec_i)) && (lvl_i == FAST_LEVEL);
    assign hit_b = (fm_b_i == DW'(vec_i)) && (lvl_i == FAST_LEVEL);

    always_comb begin
        fast_o = hit_a | hit_b;
        if (hit_a)
            addr_o = fa_a_i;
        else if (hit_b)
            addr_o = fa_b_i;
        else
            addr_o = base_i + (VA_W'(vec_i) << 1);
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter  int NUM_SRC = 16,
    parameter  int DW      = 16,
    localparam int NPR     = (2 * NUM_SRC + DW - 1) / DW,
    localparam int RAW     = $clog2(OFS_PRIO + NPR),
    localparam int VEC_W   = $clog2(NUM_SRC + 1),
    localparam int VA_W    = 2 * DW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic               nmi_i,
    input  logic [1:0]         core_lvl_i,
    input  logic               reg_wr_i,
    input  logic [RAW-1:0]     reg_addr_i,
    input  logic [DW-1:0]      reg_wdata_i,
    output logic [DW-1:0]      reg_rdata_o,
    output logic               int_req_o,
    output logic [VEC_W-1:0]   int_vec_o,
    output logic [VA_W-1:0]    int_addr_o,
    output logic               int_fast_o,
    input  logic               int_ack_i
);
    localparam int N       = NUM_SRC + 1;
    localparam int NMI_IDX = NUM_SRC;

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic [1:0]       lvl;
        logic [VA_W-1:0]  addr;
        logic             fast;
    } grant_t;

    logic [VA_W-1:0]          base_w, fa_a_w, fa_b_w;
    logic [DW-1:0]            fm_a_w, fm_b_w;
    logic [NUM_SRC-1:0][1:0]  field_w;
    logic [N-1:0]             en_w, pend_w;
    logic [N-1:0][1:0]        lvl_w;
    logic                     win_valid;
    logic [VEC_W-1:0]         win_vec;
    logic [1:0]               win_lvl;
    grant_t                   cand, grant_q;
    logic                     req_q;
    logic                     clr_w;

    pic_regs #(.NUM_SRC(NUM_SRC), .DW(DW), .NPR(NPR), .RAW(RAW)) u_regs (
        .clk(clk), .rst(rst),
        .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .rdata_o(reg_rdata_o),
        .base_o(base_w), .fm_a_o(fm_a_w), .fm_b_o(fm_b_w),
        .fa_a_o(fa_a_w), .fa_b_o(fa_b_w), .prio_o(field_w)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign en_w[i]  = field_enabled(field_w[i]);
        assign lvl_w[i] = field_level(field_w[i]);
    end
    assign en_w[NMI_IDX]  = 1'b1;
    assign lvl_w[NMI_IDX] = NMI_LEVEL;

    assign clr_w = req_q & int_ack_i;

    pic_pending #(.N(N), .VEC_W(VEC_W)) u_pend (
        .clk(clk), .rst(rst),
        .line_i({nmi_i, irq_i}), .en_i(en_w),
        .clr_i(clr_w), .clr_idx_i(grant_q.vec),
        .pend_o(pend_w)
    );

    pic_arbiter #(.N(N), .VEC_W(VEC_W)) u_arb (
        .req_i(pend_w & en_w), .lvl_i(lvl_w), .core_lvl_i(core_lvl_i),
        .win_valid_o(win_valid), .win_vec_o(win_vec), .win_lvl_o(win_lvl)
    );

    pic_vecgen #(.DW(DW), .VEC_W(VEC_W)) u_vec (
        .vec_i(win_vec), .lvl_i(win_lvl), .base_i(base_w),
        .fm_a_i(fm_a_w), .fm_b_i(fm_b_w), .fa_a_i(fa_a_w), .fa_b_i(fa_b_w),
        .addr_o(cand.addr), .fast_o(cand.fast)
    );
    assign cand.vec = win_vec;
    assign cand.lvl = win_lvl;

    // presented request: loaded when idle, frozen until acknowledged
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            grant_q <= '0;
        end else if (req_q) begin
            if (int_ack_i) req_q <= 1'b0;
        end else if (win_valid) begin
            req_q   <= 1'b1;
            grant_q <= cand;
        end
    end

    assign int_req_o  = req_q;
    assign int_vec_o  = grant_q.vec;
    assign int_addr_o = grant_q.addr;
    assign int_fast_o = grant_q.fast;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        int_req_o && !int_ack_i |=> int_req_o && $stable(int_vec_o)
                                    && $stable(int_addr_o) && $stable(int_fast_o)); // R11

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
        int_req_o && int_ack_i |=> !int_req_o); // R11

    AST_FAST_LVL2: assert property (@(posedge clk) disable iff (rst)
        int_req_o && int_fast_o |-> grant_q.lvl == FAST_LEVEL); // R8

    AST_NMI_WINS: assert property (@(posedge clk) disable iff (rst)
        pend_w[NMI_IDX] && !int_req_o |=> int_req_o && int_vec_o == VEC_W'(NMI_IDX)); // R6

    AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> win_lvl >= core_lvl_i); // R4

endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    localparam int NSRC = 16;
    localparam logic [31:0] BASE = 32'h0002_0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq = '0;
    logic        nmi = 1'b0;
    logic [1:0]  core_lvl = 2'b00;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        int_req;
    logic [4:0]  int_vec;
    logic [31:0] int_addr;
    logic        int_fast;
    logic        int_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    logic [15:0] pr [2] = '{16'h0, 16'h0};

    always #2 clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(NSRC), .DW(16)) u_dut (
        .clk(clk), .rst(rst), .irq_i(irq), .nmi_i(nmi), .core_lvl_i(core_lvl),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .int_req_o(int_req), .int_vec_o(int_vec),
        .int_addr_o(int_addr), .int_fast_o(int_fast), .int_ack_i(int_ack)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [15:0] exp, input string req);
        @(negedge clk);
        reg_addr = 4'(a);
        #1;
        chk(reg_rdata == exp, req, $sformatf("readback @%0d", a), reg_rdata, exp);
    endtask

    task automatic set_prio(input int src, input logic [1:0] f);
        pr[src/8][2*(src%8) +: 2] = f;
        wr(8 + src/8, pr[src/8]);
    endtask

    task automatic pulse(input logic [15:0] m, input logic n);
        @(negedge clk);
        irq = irq | m; nmi = n;
        @(negedge clk);
        irq = irq & ~m; nmi = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
        #1;
        chk(int_req == 1'b0, "R11", "strobe after ack", int_req, 0);
    endtask

    task automatic expect_grant(input string req, input int vec,
                                input logic [31:0] addr, input logic fast);
        for (int i = 0; i < 10 && !int_req; i++) @(negedge clk);
        #1;
        chk(int_req == 1'b1, req, "request raised", int_req, 1);
        chk(int_vec == 5'(vec), req, "vector", int_vec, vec);
        chk(int_addr == addr, req, "address", int_addr, addr);
        chk(int_fast == fast, req, "fast flag", int_fast, fast);
    endtask

    task automatic expect_idle(input string req, input int cyc);
        int seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            #1;
            if (int_req) seen = 1;
        end
        chk(seen == 0, req, "no request", seen, 0);
    endtask

    task automatic t_reset();
        chk(int_req == 1'b0, "R1", "strobe after reset", int_req, 0);
        for (int a = 0; a < 10; a++) rd_chk(a, 16'h0, "R1");
    endtask

    task automatic t_regs();
        for (int a = 0; a < 10; a++) wr(a, 16'h1111 * 16'(a + 1) ^ 16'h0F0F);
        for (int a = 0; a < 10; a++) rd_chk(a, 16'h1111 * 16'(a + 1) ^ 16'h0F0F, "R2");
        rd_chk(10, 16'h0, "R2");
        wr(0, BASE[15:0]); wr(1, BASE[31:16]);
        wr(2, 16'd31); wr(3, 16'd31);
        wr(8, 16'h0); wr(9, 16'h0);
    endtask

    task automatic t_normal();
        set_prio(5, 2'b01);
        pulse(16'h0020, 1'b0);
        expect_grant("R7", 5, BASE + 32'd10, 1'b0);
        ack();
        @(negedge clk); irq[5] = 1'b1;
        expect_grant("R3", 5, BASE + 32'd10, 1'b0);
        ack();
        expect_idle("R3", 5);
        irq[5] = 1'b0;
    endtask

    task automatic t_disabled();
        pulse(16'h0008, 1'b0);
        set_prio(3, 2'b01);
        expect_idle("R3", 5);
        set_prio(3, 2'b00);
    endtask

    task automatic t_level();
        core_lvl = 2'b10;
        set_prio(8, 2'b10);
        pulse(16'h0100, 1'b0);
        expect_idle("R4", 5);
        core_lvl = 2'b01;
        expect_grant("R4", 8, BASE + 32'd16, 1'b0);
        ack();
        core_lvl = 2'b00;
    endtask

    task automatic t_prio();
        set_prio(7, 2'b01); set_prio(9, 2'b11); set_prio(4, 2'b11);
        pulse(16'h0290, 1'b0);
        expect_grant("R5", 4, BASE + 32'd8, 1'b0);
        ack();
        expect_grant("R5", 9, BASE + 32'd18, 1'b0);
        ack();
        expect_grant("R5", 7, BASE + 32'd14, 1'b0);
        ack();
    endtask

    task automatic t_nmi();
        core_lvl = 2'b11;
        pulse(16'h0010, 1'b1);
        expect_grant("R6", 16, BASE + 32'd32, 1'b0);
        ack();
        expect_idle("R4", 5);
        core_lvl = 2'b00;
        expect_grant("R4", 4, BASE + 32'd8, 1'b0);
        ack();
    endtask

    task automatic t_fast();
        wr(2, 16'd6); wr(4, 16'h1234); wr(5, 16'hABCD);
        set_prio(6, 2'b11);
        pulse(16'h0040, 1'b0);
        expect_grant("R8", 6, 32'hABCD_1234, 1'b1);
        ack();
        wr(3, 16'd6); wr(6, 16'h5678); wr(7, 16'h0FED);
        pulse(16'h0040, 1'b0);
        expect_grant("R10", 6, 32'hABCD_1234, 1'b1);
        ack();
        wr(3, 16'd11); set_prio(11, 2'b11);
        pulse(16'h0800, 1'b0);
        expect_grant("R8", 11, 32'h0FED_5678, 1'b1);
        ack();
        set_prio(6, 2'b10);
        pulse(16'h0040, 1'b0);
        expect_grant("R9", 6, BASE + 32'd12, 1'b0);
        ack();
        set_prio(11, 2'b01);
        pulse(16'h0800, 1'b0);
        expect_grant("R9", 11, BASE + 32'd22, 1'b0);
        ack();
    endtask

    task automatic t_hold();
        pulse(16'h0020, 1'b0);
        expect_grant("R11", 5, BASE + 32'd10, 1'b0);
        pulse(16'h0200, 1'b0);
        core_lvl = 2'b11;
        repeat (4) @(negedge clk);
        #1;
        chk(int_req && int_vec == 5'd5 && int_addr == BASE + 32'd10, "R11",
            "held request", {int_req, int_vec, int_addr}, {1'b1, 5'd5, BASE + 32'd10});
        core_lvl = 2'b00;
        ack();
        expect_grant("R11", 9, BASE + 32'd18, 1'b0);
        ack();
        core_lvl = 2'b11;
        pulse(16'h0020, 1'b0);
        @(negedge clk); int_ack = 1'b1;
        @(negedge clk); int_ack = 1'b0;
        core_lvl = 2'b00;
        expect_grant("R11", 5, BASE + 32'd10, 1'b0);
        ack();
    endtask

    task automatic t_same_cycle();
        pulse(16'h0020, 1'b0);
        expect_grant("R12", 5, BASE + 32'd10, 1'b0);
        @(negedge clk); int_ack = 1'b1; irq[5] = 1'b1;
        @(negedge clk); int_ack = 1'b0; irq[5] = 1'b0;
        #1;
        chk(int_req == 1'b0, "R12", "strobe gap", int_req, 0);
        expect_grant("R12", 5, BASE + 32'd10, 1'b0);
        ack();
        expect_idle("R12", 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_normal();
        t_disabled();
        t_level();
        t_prio();
        t_nmi();
        t_fast();
        t_hold();
        t_same_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule